// File: doc/BRIEF.md
# Packed Byte Multiply-Accumulate Execution Unit

This unit executes one packed SIMD instruction on 32-bit words made of four unsigned byte lanes. In each lane it multiplies a byte of the first multiplicand word by the byte in the same lane of the second multiplicand word. It then adds that product to the matching byte of an accumulator word, or subtracts the product from it. Each lane result is cut to 8 bits, and the four results are packed into one 32-bit word that is written back to a destination register.

The unit sits beside a register file. It receives a 32-bit instruction word with a valid strobe and decodes the register and pattern fields. It drives three read indices at once, as combinational outputs, and takes the three operand words back in the same cycle. One clock later it presents the destination index, the packed result and a write strobe. A new instruction can be accepted on every cycle.

Top module: `qmac_unit`

## Requirements
- R1: An instruction is accepted only when the valid strobe is high and instruction bits [5:0] equal 0x3C. For any other opcode value, or with the strobe low, the write strobe stays low in the following cycle.
- R2: The read indices are combinational copies of instruction fields. The accumulator index is bits [9:6], the first multiplicand index is bits [13:10] and the second multiplicand index is bits [17:14].
- R3: With a write, the destination index is the value of instruction bits [21:18].
- R4: Lane i takes bits [8i+7:8i] of each operand word, for i from 0 to 3. The two multiplicand bytes are multiplied as unsigned numbers.
- R5: Pattern bit 0 is instruction bit 24. When it is 1, lanes 0 and 1 produce the accumulator byte minus the product. When it is 0, they produce the accumulator byte plus the product.
- R6: Pattern bit 1 is instruction bit 25. It selects add (0) or subtract (1) for lanes 2 and 3 in the same way.
- R7: Each lane keeps only the low 8 bits of its result. Overflow and underflow wrap silently, with no saturation and no carry or borrow into a neighbouring lane.
- R8: The written word holds lane 0 in bits [7:0], lane 1 in [15:8], lane 2 in [23:16] and lane 3 in [31:24].
- R9: The result and the write strobe appear exactly one clock after the instruction is presented. Instructions on consecutive cycles each produce their own write on consecutive cycles.
- R10: While the active-low reset is low at a clock edge, the write strobe, destination index and write data all become zero, whatever the instruction inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| rs_acc_idx_o | output | 4 | Read index of the accumulator register |
| rs_mula_idx_o | output | 4 | Read index of the first multiplicand register |
| rs_mulb_idx_o | output | 4 | Read index of the second multiplicand register |
| acc_data_i | input | 32 | Accumulator register contents |
| mula_data_i | input | 32 | First multiplicand register contents |
| mulb_data_i | input | 32 | Second multiplicand register contents |
| rd_idx_o | output | 4 | Destination register index |
| rd_data_o | output | 32 | Packed result |
| rd_we_o | output | 1 | Write strobe for the destination register |

## Verification
The assertions assume that the three operand words belong to the instruction presented in the same cycle. In other words, the register file returns the contents for the indices the unit drives, without delay. They also assume that the instruction and operand inputs are known values whenever reset is released. The bench meets both conditions. It holds a register-file model that reads combinationally from the unit's indices. It sets operand registers and instruction inputs only between clock edges, and it starts every input at zero. When a result must feed the next instruction, the bench writes it into its model as soon as the result is seen, which acts as forwarding.

// File: rtl/qmac_pkg.sv
package qmac_pkg;

    localparam int WORD_W        = 32;
    localparam int LANE_W        = 8;
    localparam int LANES         = WORD_W / LANE_W;
    localparam int IDX_W         = 4;
    localparam int PAT_W         = 2;
    localparam int LANES_PER_PAT = LANES / PAT_W;
    localparam int OPC_W         = 6;
    localparam logic [OPC_W-1:0] OPC_QMAC = 6'h3C;

    localparam int ACC_LSB  = 6;
    localparam int MULA_LSB = 10;
    localparam int MULB_LSB = 14;
    localparam int DST_LSB  = 18;
    localparam int PAT_LSB  = 24;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] acc_idx;
        logic [IDX_W-1:0] mula_idx;
        logic [IDX_W-1:0] mulb_idx;
        logic [IDX_W-1:0] dst_idx;
        logic [PAT_W-1:0] pat;
    } dec_t;

    typedef struct packed {
        logic              we;
        logic [IDX_W-1:0]  dst;
        logic [WORD_W-1:0] data;
    } wb_t;

endpackage

// File: rtl/qmac_decode.sv
module qmac_decode
    import qmac_pkg::*;
(
    input  logic [WORD_W-1:0] instr_i,
    input  logic              valid_i,
    output dec_t              dec_o
);

    dec_t dec_d;

    always_comb begin
        dec_d          = '0;
        dec_d.hit      = valid_i && (instr_i[OPC_W-1:0] == OPC_QMAC);
        dec_d.acc_idx  = instr_i[ACC_LSB  +: IDX_W];
        dec_d.mula_idx = instr_i[MULA_LSB +: IDX_W];
        dec_d.mulb_idx = instr_i[MULB_LSB +: IDX_W];
        dec_d.dst_idx  = instr_i[DST_LSB  +: IDX_W];
        dec_d.pat      = instr_i[PAT_LSB  +: PAT_W];
    end

    assign dec_o = dec_d;

    logic unused_fields;
    assign unused_fields = ^{instr_i[WORD_W-1:PAT_LSB+PAT_W],
                             instr_i[PAT_LSB-1:DST_LSB+IDX_W]};

endmodule

// File: rtl/qmac_lane.sv
module qmac_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] mula_i,
    input  logic [W-1:0] mulb_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o
);

    logic [W-1:0] prod_lo;
    logic [W-1:0] res_d;

    always_comb begin
        prod_lo = mula_i * mulb_i;
        if (sub_i) begin
            res_d = acc_i - prod_lo;
        end else begin
            res_d = acc_i + prod_lo;
        end
    end

    assign res_o = res_d;

endmodule

// File: rtl/qmac_unit.sv
module qmac_unit
    import qmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr_i,
    input  logic              instr_valid_i,
    output logic [3:0]        rs_acc_idx_o,
    output logic [3:0]        rs_mula_idx_o,
    output logic [3:0]        rs_mulb_idx_o,
    input  logic [31:0]       acc_data_i,
    input  logic [31:0]       mula_data_i,
    input  logic [31:0]       mulb_data_i,
    output logic [3:0]        rd_idx_o,
    output logic [31:0]       rd_data_o,
    output logic              rd_we_o
);

    dec_t              dec;
    logic [WORD_W-1:0] lane_word;
    wb_t               wb_d;
    wb_t               wb_q;

    qmac_decode u_dec (
        .instr_i (instr_i),
        .valid_i (instr_valid_i),
        .dec_o   (dec)
    );

    assign rs_acc_idx_o  = dec.acc_idx;
    assign rs_mula_idx_o = dec.mula_idx;
    assign rs_mulb_idx_o = dec.mulb_idx;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        qmac_lane #(.W(LANE_W)) u_lane (
            .acc_i  (acc_data_i [g*LANE_W +: LANE_W]),
            .mula_i (mula_data_i[g*LANE_W +: LANE_W]),
            .mulb_i (mulb_data_i[g*LANE_W +: LANE_W]),
            .sub_i  (dec.pat[g / LANES_PER_PAT]),
            .res_o  (lane_word  [g*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        wb_d    = wb_q;
        wb_d.we = dec.hit;
        if (dec.hit) begin
            wb_d.dst  = dec.dst_idx;
            wb_d.data = lane_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_q <= '0;
        end else begin
            wb_q <= wb_d;
        end
    end

    assign rd_we_o   = wb_q.we;
    assign rd_idx_o  = wb_q.dst;
    assign rd_data_o = wb_q.data;

endmodule

// File: rtl/qmac_unit_chk.sv
module qmac_unit_chk
    import qmac_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] instr_i,
    input logic        instr_valid_i,
    input logic [3:0]  rs_acc_idx_o,
    input logic [3:0]  rs_mula_idx_o,
    input logic [3:0]  rs_mulb_idx_o,
    input logic [31:0] acc_data_i,
    input logic [31:0] mula_data_i,
    input logic [31:0] mulb_data_i,
    input logic [3:0]  rd_idx_o,
    input logic [31:0] rd_data_o,
    input logic        rd_we_o
);

    logic              accept;
    logic [WORD_W-1:0] model_w;

    assign accept = instr_valid_i && (instr_i[5:0] == OPC_QMAC);

    always_comb begin
        model_w = '0;
        for (int i = 0; i < LANES; i++) begin
            logic [LANE_W-1:0] a, b, c, p;
            a = acc_data_i [i*LANE_W +: LANE_W];
            b = mula_data_i[i*LANE_W +: LANE_W];
            c = mulb_data_i[i*LANE_W +: LANE_W];
            p = b * c;
            if (instr_i[24 + i/2]) model_w[i*LANE_W +: LANE_W] = a - p;
            else                   model_w[i*LANE_W +: LANE_W] = a + p;
        end
    end

    always_comb begin
        AST_READ_IDX: assert (rs_acc_idx_o == instr_i[9:6] &&
                              rs_mula_idx_o == instr_i[13:10] &&
                              rs_mulb_idx_o == instr_i[17:14]); // R2
    end

    AST_ACCEPT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rd_we_o); // R9

    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !rd_we_o); // R1

    AST_DEST_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (rd_idx_o == $past(instr_i[21:18]))); // R3

    AST_LANE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (rd_data_o == $past(model_w))); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!rd_we_o && rd_data_o == '0 && rd_idx_o == '0)); // R10

    logic unused_bits;
    assign unused_bits = ^{instr_i[31:26], instr_i[23:22]};

endmodule

bind qmac_unit qmac_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_i       (instr_i),
    .instr_valid_i (instr_valid_i),
    .rs_acc_idx_o  (rs_acc_idx_o),
    .rs_mula_idx_o (rs_mula_idx_o),
    .rs_mulb_idx_o (rs_mulb_idx_o),
    .acc_data_i    (acc_data_i),
    .mula_data_i   (mula_data_i),
    .mulb_data_i   (mulb_data_i),
    .rd_idx_o      (rd_idx_o),
    .rd_data_o     (rd_data_o),
    .rd_we_o       (rd_we_o)
);

// File: tb/qmac_unit_test.sv
`timescale 1ns/1ps
module qmac_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic        instr_valid = 1'b0;
    logic [3:0]  rs_acc_idx, rs_mula_idx, rs_mulb_idx;
    logic [31:0] acc_data, mula_data, mulb_data;
    logic [3:0]  rd_idx;
    logic [31:0] rd_data;
    logic        rd_we;

    logic [31:0] rf [16];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic        pend = 1'b0;
    logic [3:0]  pend_dst = '0;
    logic [31:0] pend_data = '0;
    string       pend_req = "";

    always #4 clk = ~clk;

    assign acc_data  = rf[rs_acc_idx];
    assign mula_data = rf[rs_mula_idx];
    assign mulb_data = rf[rs_mulb_idx];

    qmac_unit uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_i       (instr),
        .instr_valid_i (instr_valid),
        .rs_acc_idx_o  (rs_acc_idx),
        .rs_mula_idx_o (rs_mula_idx),
        .rs_mulb_idx_o (rs_mulb_idx),
        .acc_data_i    (acc_data),
        .mula_data_i   (mula_data),
        .mulb_data_i   (mulb_data),
        .rd_idx_o      (rd_idx),
        .rd_data_o     (rd_data),
        .rd_we_o       (rd_we)
    );

    // stimulus vectors: {pattern, acc, mula, mulb}
    localparam int NVEC = 8;
    localparam logic [97:0] VEC [NVEC] = '{
        {2'd0, 32'h12345678, 32'h01020304, 32'h05060708},
        {2'd1, 32'h80808080, 32'h10203040, 32'h02020202},
        {2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
        {2'd3, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF},
        {2'd0, 32'hA5A55A5A, 32'h0F0F0F0F, 32'h11111111},
        {2'd1, 32'h7F7F7F7F, 32'h80FF0180, 32'h02FF0102},
        {2'd2, 32'h00FF00FF, 32'h01010101, 32'h01010101},
        {2'd3, 32'hDEADBEEF, 32'h13579BDF, 32'h2468ACE0}
    };

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [3:0] a,
                                       input logic [3:0] b, input logic [3:0] c,
                                       input logic [3:0] d, input logic [1:0] pat);
        return {6'h1C, pat, 2'b00, d, c, b, a, op};
    endfunction

    function automatic logic [31:0] ref_model(input logic [31:0] acc, input logic [31:0] x,
                                              input logic [31:0] y, input logic [1:0] pat);
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++) begin
            logic [15:0] full;
            logic [7:0]  lo;
            full = 16'(x[8*i +: 8]) * 16'(y[8*i +: 8]);
            lo   = full[7:0];
            r[8*i +: 8] = pat[i/2] ? (acc[8*i +: 8] - lo) : (acc[8*i +: 8] + lo);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: verify the previous result, optionally load operands, drive a new instruction.
    task automatic step(input logic [31:0] ins, input logic v, input logic ld,
                        input logic [31:0] pa, input logic [31:0] pb, input logic [31:0] pc,
                        input logic use_hand, input logic [31:0] hand, input string req);
        @(negedge clk);
        if (pend) begin
            check({pend_req, " R9 write strobe"}, {31'd0, rd_we}, 32'd1);
            check({pend_req, " R3 dest"}, {28'd0, rd_idx}, {28'd0, pend_dst});
            check(pend_req, rd_data, pend_data);
            rf[pend_dst] = pend_data;
        end else begin
            check("R1 no write", {31'd0, rd_we}, 32'd0);
        end
        if (ld) begin
            rf[ins[9:6]]   = pa;
            rf[ins[13:10]] = pb;
            rf[ins[17:14]] = pc;
        end
        instr       = ins;
        instr_valid = v;
        pend      = v && (ins[5:0] == 6'h3C);
        pend_dst  = ins[21:18];
        pend_data = use_hand ? hand
                  : ref_model(rf[ins[9:6]], rf[ins[13:10]], rf[ins[17:14]], ins[25:24]);
        pend_req  = req;
        #1;
        check("R2 read indices", {20'd0, rs_acc_idx, rs_mula_idx, rs_mulb_idx},
              {20'd0, ins[9:6], ins[13:10], ins[17:14]});
    endtask

    initial begin
        #(8 * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = 32'h0;
        instr       = mk(6'h3C, 4'd1, 4'd2, 4'd3, 4'd4, 2'd0);
        instr_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R10: held in reset with a valid instruction present
        check("R10 reset we", {31'd0, rd_we}, 32'd0);
        check("R10 reset data", rd_data, 32'd0);
        check("R10 reset dest", {28'd0, rd_idx}, 32'd0);
        instr_valid = 1'b0;
        rst_n = 1'b1;

        // table walk, back-to-back issue (R9), all patterns (R5, R6)
        for (int i = 0; i < NVEC; i++) begin
            step(mk(6'h3C, 4'd1, 4'd2, 4'd3, 4'(4 + i), VEC[i][97:96]), 1'b1, 1'b1,
                 VEC[i][95:64], VEC[i][63:32], VEC[i][31:0], 1'b0, 32'd0, "R4 R5 R6 table");
        end

        // R1: neighbouring opcodes and dropped strobe give no write
        step(mk(6'h3B, 4'd1, 4'd2, 4'd3, 4'd9, 2'd0), 1'b1, 1'b0, 0, 0, 0, 1'b0, 0, "R1");
        step(mk(6'h3D, 4'd1, 4'd2, 4'd3, 4'd9, 2'd0), 1'b1, 1'b0, 0, 0, 0, 1'b0, 0, "R1");
        step(mk(6'h3C, 4'd1, 4'd2, 4'd3, 4'd9, 2'd0), 1'b0, 1'b0, 0, 0, 0, 1'b0, 0, "R1");

        // R7: 0xFF*0xFF, low byte 0x01
        step(mk(6'h3C, 4'd1, 4'd2, 4'd3, 4'd12, 2'd0), 1'b1, 1'b1,
             32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 32'h01010101, "R7 ff*ff add");
        step(mk(6'h3C, 4'd1, 4'd2, 4'd3, 4'd12, 2'd0), 1'b1, 1'b1,
             32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 32'h00000000, "R7 ff*ff add wrap");
        step(mk(6'h3C, 4'd1, 4'd2, 4'd3, 4'd12, 2'd3), 1'b1, 1'b1,
             32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFFF, "R7 ff*ff sub wrap");
        step(mk(6'h3C, 4'd1, 4'd2, 4'd3, 4'd12, 2'd1), 1'b1, 1'b1,
             32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 32'h0101FFFF, "R5 R6 split pattern");
        step(mk(6'h3C, 4'd1, 4'd2, 4'd3, 4'd12, 2'd2), 1'b1, 1'b1,
             32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 32'hFFFF0101, "R6 upper lanes sub");
        // R7: no carry between lanes
        step(mk(6'h3C, 4'd1, 4'd2, 4'd3, 4'd12, 2'd0), 1'b1, 1'b1,
             32'h00FF00FF, 32'h01010101, 32'h01010101, 1'b1, 32'h01000100, "R7 no carry");
        // R8, R4: lane order
        step(mk(6'h3C, 4'd1, 4'd2, 4'd3, 4'd12, 2'd0), 1'b1, 1'b1,
             32'h00000000, 32'h04030201, 32'h01010101, 1'b1, 32'h04030201, "R8 lane order");

        // destination equals a source register, back-to-back dependent
        step(mk(6'h3C, 4'd5, 4'd6, 4'd7, 4'd5, 2'd0), 1'b1, 1'b1,
             32'h10203040, 32'h02030405, 32'h03030303, 1'b1, 32'h16293C4F, "R3 dst=acc");
        step(mk(6'h3C, 4'd5, 4'd6, 4'd7, 4'd5, 2'd3), 1'b1, 1'b0,
             0, 0, 0, 1'b1, 32'h10203040, "R3 dst=acc again");
        step(mk(6'h3C, 4'd1, 4'd1, 4'd1, 4'd1, 2'd0), 1'b1, 1'b1,
             32'h02020202, 32'h02020202, 32'h02020202, 1'b1, 32'h06060606, "R4 one reg");
        step(32'h0, 1'b0, 1'b0, 0, 0, 0, 1'b0, 0, "idle");

        // R10: reset right after an accepted instruction
        step(mk(6'h3C, 4'd1, 4'd2, 4'd3, 4'd13, 2'd0), 1'b1, 1'b1,
             32'h11111111, 32'h01010101, 32'h01010101, 1'b0, 0, "R10 pre");
        @(negedge clk);
        pend  = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid reset we", {31'd0, rd_we}, 32'd0);
        check("R10 mid reset data", rd_data, 32'd0);
        rst_n = 1'b1;
        instr_valid = 1'b0;
        step(32'h0, 1'b0, 1'b0, 0, 0, 0, 1'b0, 0, "idle");
        step(32'h0, 1'b0, 1'b0, 0, 0, 0, 1'b0, 0, "idle");

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule